// File: doc/BRIEF.md
# Comparand and Mask Shifter with Run-Time Field Width

This block holds the two search-key registers of a content-addressable search engine: a comparand and a mask. Either register can be loaded in parallel. Either register can also be moved by one bit position per command, toward the top or toward bit 0. The two registers move in different ways. The comparand rotates, so the bit leaving one end re-enters at the other. The mask slides, so the bit leaving one end is lost and the bit at the far end is copied inward.

Every shift is confined to an active field that starts at bit 0. A 2-bit partition input sets the width of this field at run time. The top end of every shift follows the top of the active field. Bits above the field belong to the data (RAM) portion of the word and are never altered by a shift.

Top module: `cmp_mask_shifter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `cmp_q` and `msk_q` become all zeros, whatever the other inputs are.
- R2: With `load_en`=1 and `load_sel`=0, `cmp_q` takes all 64 bits of `load_data` at the next edge, and `msk_q` is unchanged.
- R3: With `load_en`=1 and `load_sel`=1, `msk_q` takes all 64 bits of `load_data` at the next edge, and `cmp_q` is unchanged.
- R4: When `load_en`=1, any `shift_en` in the same cycle is ignored: only the load takes effect.
- R5: Comparand right shift (`shift_dir`=0, `shift_sel`=0): for field top T, each bit i<T takes old bit i+1, and bit T takes old bit 0.
- R6: Comparand left shift (`shift_dir`=1, `shift_sel`=0): each bit i in 1..T takes old bit i-1, and bit 0 takes old bit T.
- R7: Mask right shift (`shift_dir`=0, `shift_sel`=1): each bit i<T takes old bit i+1. Old bit 0 is discarded. Bit T keeps its value.
- R8: Mask left shift (`shift_dir`=1, `shift_sel`=1): each bit i in 1..T takes old bit i-1. Old bit T is discarded. Bit 0 keeps its value.
- R9: `part_width` sets the field width: 0 gives 16 bits (T=15), 1 gives 32 (T=31), 2 gives 48 (T=47), and 3 gives 64 (T=63).
- R10: During any shift, the bits above T in the shifted register keep their values.
- R11: A shift command changes only the register named by `shift_sel`. The other register holds its value.
- R12: With `load_en`=0 and `shift_en`=0, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Parallel load request |
| load_sel | input | 1 | Load target: 0 comparand, 1 mask |
| load_data | input | 64 | Value to load |
| shift_en | input | 1 | One-bit shift request |
| shift_dir | input | 1 | 0 toward bit 0, 1 toward the top |
| shift_sel | input | 1 | Shift target: 0 comparand, 1 mask |
| part_width | input | 2 | Active field width code |
| cmp_q | output | 64 | Comparand register |
| msk_q | output | 64 | Mask register |

## Verification
Every command (reset, load or shift) is registered in a single stage. Its result therefore appears on `cmp_q` and `msk_q` after the first rising edge that samples it, and no later. The bench drives each command just after a falling edge. It predicts both registers from its own bit-level model before the rising edge arrives. It then compares both outputs at the next falling edge, half a period after the update. The stimulus covers all four widths, both directions, both targets, colliding load and shift, and idle cycles. Each comparison is tagged with the requirement the command exercises.

// File: rtl/cms_pkg.sv
// Package: shared sizes and command encodings for the comparand/mask shifter.
// Assumes the register width is a whole multiple of the width granule.
package cms_pkg;
    localparam int unsigned CMS_DATA_W = 64;
    localparam int unsigned CMS_SEG_W  = 16;

    // Register select: this encoding is used by both load and shift.
    typedef enum logic {
        SEL_CMP = 1'b0,
        SEL_MSK = 1'b1
    } reg_sel_e;

    // Shift direction.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } shift_dir_e;
endpackage

// File: rtl/cms_field_decode.sv
// Module: turns the partition code into the index of the top field bit and
// a mask of the bits inside the field. Code p selects (p+1)*SEG_W bits.
// Assumes DATA_W == SEG_W * 2**PART_W.
module cms_field_decode #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned PART_W = 2,
    parameter int unsigned IDX_W  = 6
) (
    input  logic [PART_W-1:0] part,
    output logic [IDX_W-1:0]  top_idx,
    output logic [DATA_W-1:0] field_mask
);
    localparam int unsigned NUM_SEG = DATA_W / SEG_W;

    // Purpose: index of the highest bit inside the field.
    always_comb begin
        top_idx = IDX_W'((32'(part) + 32'd1) * SEG_W - 32'd1);
    end

    // Purpose: segment s lies inside the field when the code is at least s.
    genvar s;
    generate
        for (s = 0; s < NUM_SEG; s++) begin : g_seg
            assign field_mask[s*SEG_W +: SEG_W] =
                {SEG_W{(32'(part) >= s)}};
        end
    endgenerate
endmodule

// File: rtl/cms_shift_net.sv
// Module: combinational next value for a one-bit move inside the field.
// ROTATE=1 wraps the bit that leaves the field back in at the other end.
// ROTATE=0 lets that bit fall off, and the end bit copies its own value.
// Bits outside field_mask pass through unchanged. Assumes bit 0 is always
// inside the field.
module cms_shift_net #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 6,
    parameter bit          ROTATE = 1'b1
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [IDX_W-1:0]  top_idx,
    input  logic [DATA_W-1:0] field_mask,
    input  logic              dir_up,
    output logic [DATA_W-1:0] nxt
);
    logic top_bit;

    // Purpose: pick the value currently held at the top of the field.
    always_comb begin
        top_bit = cur[top_idx];
    end

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_bit
            localparam int unsigned ABOVE = (i < DATA_W - 1) ? i + 1 : i;
            localparam int unsigned BELOW = (i > 0) ? i - 1 : 0;
            logic at_top;
            logic down_val;
            logic up_val;

            assign at_top = (top_idx == IDX_W'(i));

            // Purpose: value for this bit when moving toward bit 0.
            always_comb begin
                if (at_top) begin
                    down_val = ROTATE ? cur[0] : cur[i];
                end else if (field_mask[i]) begin
                    down_val = cur[ABOVE];
                end else begin
                    down_val = cur[i];
                end
            end

            // Purpose: value for this bit when moving toward the top.
            if (i == 0) begin : g_low
                always_comb begin
                    up_val = ROTATE ? top_bit : cur[0];
                end
            end else begin : g_mid
                always_comb begin
                    up_val = field_mask[i] ? cur[BELOW] : cur[i];
                end
            end

            assign nxt[i] = dir_up ? up_val : down_val;
        end
    endgenerate
endmodule

// File: rtl/cms_reg_slot.sv
// Module: one key register with a synchronous active-low clear, a parallel
// load and a shift update. Assumes the caller never asserts both strobes.
module cms_reg_slot #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_val,
    output logic [DATA_W-1:0] q
);
    // Purpose: clear, load or shift the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld_en) begin
            q <= ld_val;
        end else if (upd_en) begin
            q <= upd_val;
        end
    end
endmodule

// File: rtl/cmp_mask_shifter.sv
// Module: comparand (rotating) and mask (sliding) registers. Shifts are
// limited to a run-time field width. A load beats a shift in the same cycle.
// Each shift acts only on the register named by shift_sel.
// Assumes DATA_W is a power-of-two multiple of SEG_W.
module cmp_mask_shifter
    import cms_pkg::*;
#(
    parameter int unsigned DATA_W = CMS_DATA_W,
    parameter int unsigned SEG_W  = CMS_SEG_W,
    parameter int unsigned PART_W = $clog2(DATA_W / SEG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_sel,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_en,
    input  logic              shift_dir,
    input  logic              shift_sel,
    input  logic [PART_W-1:0] part_width,
    output logic [DATA_W-1:0] cmp_q,
    output logic [DATA_W-1:0] msk_q
);
    localparam int unsigned IDX_W  = $clog2(DATA_W);
    localparam int unsigned N_SLOT = 2;

    logic [IDX_W-1:0]  top_idx;
    logic [DATA_W-1:0] field_mask;
    logic [DATA_W-1:0] slot_q   [N_SLOT];
    logic [DATA_W-1:0] slot_nxt [N_SLOT];
    reg_sel_e          ld_tgt;
    reg_sel_e          sh_tgt;
    shift_dir_e        sh_dir;

    // Purpose: view the raw select and direction pins as typed codes.
    always_comb begin
        ld_tgt = reg_sel_e'(load_sel);
        sh_tgt = reg_sel_e'(shift_sel);
        sh_dir = shift_dir_e'(shift_dir);
    end

    cms_field_decode #(
        .DATA_W (DATA_W),
        .SEG_W  (SEG_W),
        .PART_W (PART_W),
        .IDX_W  (IDX_W)
    ) u_decode (
        .part       (part_width),
        .top_idx    (top_idx),
        .field_mask (field_mask)
    );

    // Slot 0 is the rotating comparand; slot 1 is the sliding mask.
    genvar g;
    generate
        for (g = 0; g < N_SLOT; g++) begin : g_slot
            logic ld_hit;
            logic sh_hit;

            assign ld_hit = load_en && (ld_tgt == reg_sel_e'(g));
            assign sh_hit = shift_en && !load_en && (sh_tgt == reg_sel_e'(g));

            cms_shift_net #(
                .DATA_W (DATA_W),
                .IDX_W  (IDX_W),
                .ROTATE (g == 0)
            ) u_net (
                .cur        (slot_q[g]),
                .top_idx    (top_idx),
                .field_mask (field_mask),
                .dir_up     (sh_dir == DIR_UP),
                .nxt        (slot_nxt[g])
            );

            cms_reg_slot #(
                .DATA_W (DATA_W)
            ) u_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .ld_en   (ld_hit),
                .ld_val  (load_data),
                .upd_en  (sh_hit),
                .upd_val (slot_nxt[g]),
                .q       (slot_q[g])
            );
        end
    endgenerate

    assign cmp_q = slot_q[0];
    assign msk_q = slot_q[1];
endmodule

// File: rtl/cms_shifter_chk.sv
// Module: assertion checker bound to cmp_mask_shifter. It observes ports only.
module cms_shifter_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned PART_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic              load_sel,
    input logic [DATA_W-1:0] load_data,
    input logic              shift_en,
    input logic              shift_dir,
    input logic              shift_sel,
    input logic [PART_W-1:0] part_width,
    input logic [DATA_W-1:0] cmp_q,
    input logic [DATA_W-1:0] msk_q
);
    localparam int unsigned NUM_SEG = DATA_W / SEG_W;

    logic [DATA_W-1:0] outside;

    // Purpose: bits that lie above the active field for the present code.
    always_comb begin
        outside = '1;
        for (int s = 0; s < NUM_SEG; s++) begin
            if (s <= 32'(part_width)) outside[s*SEG_W +: SEG_W] = '0;
        end
    end

    logic do_shift;
    assign do_shift = shift_en && !load_en;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cmp_q == '0 && msk_q == '0));

    assert_load_cmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !load_sel) |=> (cmp_q == $past(load_data) && $stable(msk_q)));

    assert_load_msk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_sel) |=> (msk_q == $past(load_data) && $stable(cmp_q)));

    assert_rotate_keeps_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && !shift_sel) |=> ($countones(cmp_q) == $countones($past(cmp_q))));

    assert_cmp_outside_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && !shift_sel) |=> (((cmp_q ^ $past(cmp_q)) & $past(outside)) == '0));

    assert_msk_outside_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && shift_sel) |=> (((msk_q ^ $past(msk_q)) & $past(outside)) == '0));

    assert_other_held_cmp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && !shift_sel) |=> $stable(msk_q));

    assert_other_held_msk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && shift_sel) |=> $stable(cmp_q));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> ($stable(cmp_q) && $stable(msk_q)));

    assert_msk_low_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && shift_sel && shift_dir) |=> (msk_q[0] == $past(msk_q[0])));
endmodule

bind cmp_mask_shifter cms_shifter_chk #(
    .DATA_W (DATA_W),
    .SEG_W  (SEG_W),
    .PART_W (PART_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_sel   (load_sel),
    .load_data  (load_data),
    .shift_en   (shift_en),
    .shift_dir  (shift_dir),
    .shift_sel  (shift_sel),
    .part_width (part_width),
    .cmp_q      (cmp_q),
    .msk_q      (msk_q)
);

// File: tb/sim_cmp_mask_shifter.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle model of both registers, compared on every clock.
module sim_cmp_mask_shifter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_en, load_sel, shift_en, shift_dir, shift_sel;
    logic [63:0] load_data;
    logic [1:0]  part_width;
    logic [63:0] cmp_q, msk_q;

    logic [63:0] exp_c, exp_m;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] seed  = 32'h1234_5678;

    always #4 clk = ~clk;

    cmp_mask_shifter u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sel(load_sel),
        .load_data(load_data), .shift_en(shift_en), .shift_dir(shift_dir),
        .shift_sel(shift_sel), .part_width(part_width),
        .cmp_q(cmp_q), .msk_q(msk_q)
    );

    function automatic logic [31:0] rnd(inout logic [31:0] s);
        s = s ^ (s << 13);
        s = s ^ (s >> 17);
        s = s ^ (s << 5);
        return s;
    endfunction

    // Reference move: a list of field bits turned, or slid with end copy.
    function automatic logic [63:0] model_move(logic [63:0] v, bit wrap, bit up, int w);
        bit q[$];
        logic [63:0] r = v;
        for (int k = 0; k < w; k++) q.push_back(v[k]);
        if (up) begin
            bit hi = q.pop_back();
            q.push_front(wrap ? hi : q[0]);
        end else begin
            bit lo = q.pop_front();
            q.push_back(wrap ? lo : q[q.size()-1]);
        end
        for (int k = 0; k < w; k++) r[k] = q[k];
        return r;
    endfunction

    task automatic check(string req, string nm, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
        end
    endtask

    task automatic step(bit rn, bit le, bit ls, logic [63:0] ld,
                        bit se, bit sd, bit ss, logic [1:0] pw);
        string tag;
        int    w;
        rst_n = rn; load_en = le; load_sel = ls; load_data = ld;
        shift_en = se; shift_dir = sd; shift_sel = ss; part_width = pw;
        w = (int'(pw) + 1) * 16;
        if (!rn) begin
            exp_c = '0; exp_m = '0; tag = "R1";
        end else if (le) begin
            if (ls) exp_m = ld; else exp_c = ld;
            tag = se ? "R4" : (ls ? "R3" : "R2");
        end else if (se) begin
            if (ss) begin
                exp_m = model_move(exp_m, 1'b0, sd, w);
                tag = sd ? "R8,R11" : "R7,R11";
            end else begin
                exp_c = model_move(exp_c, 1'b1, sd, w);
                tag = sd ? "R6,R11" : "R5,R11";
            end
            if (w < 64) tag = {tag, ",R9,R10"};
        end else begin
            tag = "R12";
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "cmp_q", cmp_q, exp_c);
        check(tag, "msk_q", msk_q, exp_m);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        exp_c = 'x; exp_m = 'x;
        @(negedge clk);
        // R1: reset clears both even with a load pending
        step(0, 1, 0, 64'hFFFF_0000_FFFF_0000, 0, 0, 0, 2'd3);
        step(0, 0, 0, 64'h0, 0, 0, 0, 2'd3);
        // R2, R3: full-width loads
        step(1, 1, 0, 64'h8000_0000_0000_0001, 0, 0, 0, 2'd3);
        step(1, 1, 1, 64'h8000_0000_0000_0001, 0, 0, 0, 2'd3);
        // R5..R8 at full width, T=63
        step(1, 0, 0, 64'h0, 1, 0, 0, 2'd3);
        step(1, 0, 0, 64'h0, 1, 1, 0, 2'd3);
        step(1, 0, 0, 64'h0, 1, 1, 0, 2'd3);
        step(1, 0, 0, 64'h0, 1, 0, 1, 2'd3);
        step(1, 0, 0, 64'h0, 1, 1, 1, 2'd3);
        // R4: load collides with shift
        step(1, 1, 0, 64'hDEAD_BEEF_0123_4567, 1, 1, 0, 2'd0);
        step(1, 1, 1, 64'hF00F_8001_C003_8001, 1, 0, 1, 2'd1);
        // R9, R10: each narrower width, both registers, both directions
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 2; d++) begin
                step(1, 0, 0, 64'h0, 1, d[0], 0, p[1:0]);
                step(1, 0, 0, 64'h0, 1, d[0], 1, p[1:0]);
            end
        end
        // R12: idle holds
        step(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1, 2'd2);
        // Mixed random commands
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a, b, c;
            a = rnd(seed); b = rnd(seed); c = rnd(seed);
            step((c[7:0] != 8'd0), (c[11:8] == 4'd0), c[12], {a, b},
                 (c[15:14] != 2'd0), c[16], c[17], c[19:18]);
        end
        summary();
        $finish;
    end
endmodule